// File: doc/BRIEF.md
# Addressed Serial Control Word Receiver

This block sits behind a three-line serial control port (serial clock, serial data, and a select line) and turns each transfer into one wide control word for the rest of the chip. While the select line is low, the controller clocks in an 8-bit device address. It then raises select and clocks in the control payload. All bits are taken least significant bit first, one bit on each rising serial clock edge. When select drops, the block decides whether the transfer was meant for it and whether it was well formed. If so, it moves the captured 44-bit word into a holding register and pulses a strobe. A single transfer therefore updates every field of the word at once, so level and mode settings take effect together.

Two payload lengths are legal. An exact frame carries 44 bits. A byte-aligned frame carries 48 bits, and its last four bits are filler that is thrown away. A transfer addressed to this device with any other bit count raises a one-cycle error flag and leaves the held word untouched. A transfer for some other address is ignored silently. The three serial lines are asynchronous to the system clock and are synchronized inside the block.

Top module: `ctl_rx`

## Requirements
- R1: During and right after reset, `ctl_word` is all zeros and `ctl_stb`, `frame_err` and `sel_hit` are 0.
- R2: Bits sampled on rising `ser_clk` edges while `ser_en` is low form the address, least significant bit first. The last 8 such bits count. When `ser_en` rises, `sel_hit` becomes 1 if they equal parameter `DEV_ADDR` (default 8'hA5) and 0 otherwise. `sel_hit` returns to 0 after `ser_en` falls.
- R3: Bits sampled on rising `ser_clk` edges while `ser_en` is high form the payload, least significant bit first. The first payload bit becomes `ctl_word[0]`.
- R4: If an addressed transfer ends (falling `ser_en`) with exactly 44 payload bits, `ctl_word` takes those 44 bits and `ctl_stb` is 1 for exactly one clock cycle.
- R5: If an addressed transfer ends with exactly 48 payload bits, the first 44 received bits form `ctl_word`, the final 4 are discarded, and `ctl_stb` pulses for one cycle.
- R6: If an addressed transfer ends with any other payload count (including 0 and counts above 48), `frame_err` is 1 for exactly one cycle, `ctl_stb` stays 0 and `ctl_word` is unchanged.
- R7: A transfer whose address differs from `DEV_ADDR` produces no `ctl_stb`, no `frame_err`, and no change to `ctl_word`.
- R8: `ctl_word` changes only in a cycle where `ctl_stb` is 1, and it holds its value otherwise.
- R9: `ctl_stb` or `frame_err` appears within 10 system clock cycles after `ser_en` falls, given the 2-stage input synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous; bits are taken on its rising edge |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_en | input | 1 | Select line: low for the address phase, high for the payload phase, falling edge ends the transfer |
| ctl_word | output | 44 | Held control word |
| ctl_stb | output | 1 | One-cycle pulse when `ctl_word` has been updated |
| frame_err | output | 1 | One-cycle pulse when an addressed transfer had an illegal bit count |
| sel_hit | output | 1 | High during the payload phase of a transfer addressed to this device |

## Verification
A wrong address shift or compare appears on `sel_hit` a few cycles into the payload phase. It also shows up as a missing or spurious strobe at the end of that transfer. A miscounted or misaligned payload register shows up only when `ser_en` falls, within the 10-cycle window. It appears either as the wrong event kind (strobe versus error) or as a rotated or shifted `ctl_word`. The scoreboard compares both against the expected event. Frames with filler bits that are all ones make a misplaced padding strip visible in the top bits of the word.

// File: rtl/ctl_rx_pkg.sv
package ctl_rx_pkg;
    localparam int LINES  = 3;
    localparam int LN_CLK = 0;
    localparam int LN_DAT = 1;
    localparam int LN_EN  = 2;
endpackage

// File: rtl/ctl_rx_sync.sv
module ctl_rx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // STAGES flops for metastability, one more to hold the previous level
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES:0] chain_q;
        logic [STAGES:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/ctl_rx_addr.sv
module ctl_rx_addr #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_rise,
    input  logic sdi,
    input  logic en_lvl,
    input  logic en_rise,
    input  logic en_fall,
    output logic hit
);
    typedef struct packed {
        logic [ADDR_W-1:0] sr;
        logic              hit;
    } addr_st_t;

    addr_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!en_lvl && sck_rise)
            st_d.sr = {sdi, st_q.sr[ADDR_W-1:1]};
        if (en_rise)
            st_d.hit = (st_q.sr == DEV_ADDR);
        if (en_fall)
            st_d.hit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.hit;
endmodule

// File: rtl/ctl_rx_frame.sv
module ctl_rx_frame #(
    parameter int WORD_W = 44,
    parameter int PAD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sdi,
    input  logic              en_lvl,
    input  logic              en_rise,
    input  logic              en_fall,
    input  logic              hit,
    output logic [WORD_W-1:0] word,
    output logic              stb,
    output logic              err
);
    localparam int FRAME_W = WORD_W + PAD_W;
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic [WORD_W-1:0]  word;
        logic               stb;
        logic               err;
    } frm_st_t;

    frm_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        st_d.err = 1'b0;
        if (en_rise) begin
            st_d.cnt = '0;
        end else if (en_lvl && sck_rise && hit) begin
            st_d.sr = {sdi, st_q.sr[FRAME_W-1:1]};
            if (st_q.cnt != CNT_W'(CNT_MAX))
                st_d.cnt = st_q.cnt + 1'b1;
        end
        if (en_fall && hit) begin
            if (st_q.cnt == CNT_W'(WORD_W)) begin
                // exact frame: the bits sit at the top of the shifter
                st_d.word = st_q.sr[FRAME_W-1:PAD_W];
                st_d.stb  = 1'b1;
            end else if (st_q.cnt == CNT_W'(FRAME_W)) begin
                // padded frame: the filler is at the top, so keep the low bits
                st_d.word = st_q.sr[WORD_W-1:0];
                st_d.stb  = 1'b1;
            end else begin
                st_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;
    assign stb  = st_q.stb;
    assign err  = st_q.err;
endmodule

// File: rtl/ctl_rx.sv
module ctl_rx
    import ctl_rx_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'hA5,
    parameter int                WORD_W      = 44,
    parameter int                PAD_W       = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en,
    output logic [WORD_W-1:0] ctl_word,
    output logic              ctl_stb,
    output logic              frame_err,
    output logic              sel_hit
);
    logic [LINES-1:0] lvl, rise, fall;
    logic             en_fall;

    ctl_rx_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({ser_en, ser_dat, ser_clk}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign en_fall = fall[LN_EN];

    ctl_rx_addr #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_rise(rise[LN_CLK]),
        .sdi     (lvl[LN_DAT]),
        .en_lvl  (lvl[LN_EN]),
        .en_rise (rise[LN_EN]),
        .en_fall (en_fall),
        .hit     (sel_hit)
    );

    ctl_rx_frame #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_rise(rise[LN_CLK]),
        .sdi     (lvl[LN_DAT]),
        .en_lvl  (lvl[LN_EN]),
        .en_rise (rise[LN_EN]),
        .en_fall (en_fall),
        .hit     (sel_hit),
        .word    (ctl_word),
        .stb     (ctl_stb),
        .err     (frame_err)
    );
endmodule

// File: rtl/ctl_rx_chk.sv
module ctl_rx_chk #(
    parameter int WORD_W = 44
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] ctl_word,
    input logic              ctl_stb,
    input logic              frame_err,
    input logic              sel_hit,
    input logic              en_fall
);
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ctl_stb |=> !ctl_stb); // R4
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R6
    AST_STB_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ctl_stb && frame_err)); // R6
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ctl_stb |-> $stable(ctl_word)); // R8
    AST_STB_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n) ctl_stb |-> $past(sel_hit)); // R7
    AST_EVENT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) (ctl_stb || frame_err) |-> $past(en_fall)); // R5
    AST_HIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n) en_fall |=> !sel_hit); // R2
endmodule

bind ctl_rx ctl_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_word (ctl_word),
    .ctl_stb  (ctl_stb),
    .frame_err(frame_err),
    .sel_hit  (sel_hit),
    .en_fall  (en_fall)
);

// File: tb/sim_ctl_rx.sv
`timescale 1ns/1ps
module sim_ctl_rx;
    localparam int         HP      = 4;
    localparam logic [7:0] MY_ADDR = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en = 1'b0;
    logic [43:0] ctl_word;
    logic        ctl_stb, frame_err, sel_hit;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_err;
        logic [43:0] w;
    } exp_t;

    exp_t        expq[$];
    logic [43:0] last_word = '0;

    always #10 clk = ~clk;

    ctl_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .ctl_word(ctl_word), .ctl_stb(ctl_stb), .frame_err(frame_err), .sel_hit(sel_hit)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_bit(input logic b);
        ser_dat = b;
        wait_clk(HP);
        ser_clk = 1'b1;
        wait_clk(HP);
        ser_clk = 1'b0;
    endtask

    // Driver: sends one transfer and pushes the expected outcome
    task automatic send(input logic [7:0] addr, input logic [63:0] data, input int nbits, input string req);
        bit match;
        match = (addr == MY_ADDR);
        ser_en = 1'b0;
        for (int i = 0; i < 8; i++) pulse_bit(addr[i]);
        wait_clk(HP);
        ser_en = 1'b1;
        wait_clk(2 * HP);
        @(negedge clk);
        check(sel_hit == match, {req, " R2 sel_hit"}, 64'(sel_hit), 64'(match));
        for (int i = 0; i < nbits; i++) pulse_bit(data[i]);
        wait_clk(HP);
        if (match) begin
            if (nbits == 44 || nbits == 48) begin
                expq.push_back('{is_err: 1'b0, w: data[43:0]});
                last_word = data[43:0];
            end else begin
                expq.push_back('{is_err: 1'b1, w: last_word});
            end
        end
        ser_en = 1'b0;
        wait_clk(10);
        @(negedge clk);
        check(expq.size() == 0, {req, " R9 event within window"}, 64'(expq.size()), 64'd0);
        check(ctl_word == last_word, {req, " R8 held word"}, 64'(ctl_word), 64'(last_word));
        check(sel_hit == 1'b0, {req, " R2 sel_hit after end"}, 64'(sel_hit), 64'd0);
    endtask

    // Monitor: compares each produced event with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && (ctl_stb || frame_err)) begin
            if (expq.size() == 0) begin
                check(1'b0, "R7 unexpected event", {62'd0, ctl_stb, frame_err}, 64'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.is_err) begin
                    check(frame_err && !ctl_stb, "R6 error pulse", {62'd0, ctl_stb, frame_err}, 64'd1);
                end else begin
                    check(ctl_stb && !frame_err, "R4 strobe", {62'd0, ctl_stb, frame_err}, 64'd2);
                    check(ctl_word == e.w, "R3 R5 word", 64'(ctl_word), 64'(e.w));
                end
            end
        end
    end

    initial begin
        wait_clk(3);
        @(negedge clk);
        check(ctl_word == '0 && !ctl_stb && !frame_err && !sel_hit, "R1 in reset",
              {16'd0, ctl_word, ctl_stb, frame_err, sel_hit, 1'b0}, 64'd0);
        rst_n = 1'b1;
        wait_clk(2);
        @(negedge clk);
        check(ctl_word == '0 && !ctl_stb && !frame_err && !sel_hit, "R1 after reset",
              {16'd0, ctl_word, ctl_stb, frame_err, sel_hit, 1'b0}, 64'd0);

        send(MY_ADDR, 64'h0000_0123_4567_89AB, 44, "R4 exact frame");
        send(MY_ADDR, 64'h0000_FFED_CBA9_8765, 48, "R5 padded frame ones");
        send(MY_ADDR, 64'h0000_0FFF_0000_FFFF, 43, "R6 short 43");
        send(MY_ADDR, 64'h0001_FFFF_FFFF_FFFF, 49, "R6 long 49");
        send(8'h5A,   64'h0000_0AAA_AAAA_AAAA, 44, "R7 wrong addr exact");
        send(MY_ADDR, 64'h0, 0, "R6 empty");
        send(MY_ADDR, 64'h0000_0FFF_FFFF_FFFF, 44, "R4 all ones");
        send(MY_ADDR, 64'h0000_0A5A_5A5A_5A5A, 48, "R5 padded frame zeros");
        send(MY_ADDR, 64'h0FFF_FFFF_FFFF_FFFF, 60, "R6 saturating 60");
        send(8'hA4,   64'h0000_F123_1231_2312, 48, "R7 wrong addr padded");
        send(MY_ADDR, 64'h0000_0555_5555_5555, 44, "R3 alternating");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule